// File: doc/BRIEF.md
# Phase-Accumulator PWM Bank with Latched Updates

This block produces one pulse-width-modulated output per channel. Each channel owns a single 32-bit control word reached through a plain register port (address, write strobe, write data, combinational read data). The output frequency comes from a phase accumulator. On every clock that the channel runs, the accumulator adds a programmable increment, and it wraps when the sum carries out. The duty cycle comes from an 8-bit threshold. The output is high while the upper eight accumulator bits are strictly greater than that threshold. A threshold of 255 therefore gives a permanently low output, and 0 gives an output that is high for all but the lowest slice of each period.

Writes land in a shadow copy of the increment and the threshold. The running (active) copy changes only after software sets the update-request bit. A disabled channel transfers on the next clock. A running channel transfers at the next accumulator wrap, so a period is never cut short. The request bit reads back as 1 until the transfer happens, and software polls it. The normal sequence is: program the fields with the update request, wait for the bit to clear, then set the enable bit. Disabling the channel clears only the enable bit.

Each channel is driven by a four-state controller, with the state code formed as {enable, pending}:
- `CS_STOP`: disabled, nothing pending.
- `CS_STOP_LOAD`: disabled, transfer due on the next clock.
- `CS_RUN`: enabled, nothing pending.
- `CS_RUN_ARMED`: enabled, transfer waiting for a wrap.

The transitions are:
- start (`CS_STOP`→`CS_RUN`)
- stop (`CS_RUN`→`CS_STOP`)
- arm (`CS_RUN`→`CS_RUN_ARMED`)
- commit-on-wrap (`CS_RUN_ARMED`→`CS_RUN`)
- request-idle (`CS_STOP`→`CS_STOP_LOAD`)
- commit-idle (`CS_STOP_LOAD`→`CS_STOP` or `CS_RUN`)
- stop-while-armed (`CS_RUN_ARMED`→`CS_STOP_LOAD`)
- re-arm, taken when a write carrying a new request coincides with a commit, so the request stays pending.

Top module: `acc_pwm_bank`

## Requirements
- R1: After reset, every channel's control word reads 0x00000000 and every `pwm_out` bit is 0.
- R2: Control word layout: bit 31 is enable, bit 30 is update request, bits [8+BU_W-1:8] are the increment and bits [7:0] are the threshold. A write stores enable, increment and threshold, which read back unchanged on the next cycle. Bits between the increment and bit 30 read 0.
- R3: Byte address bits [ADDR_W-1:10] select the channel (stride 0x400). Only offset 0 inside a window is decoded. Writes to any other offset change nothing, and reads from such an offset return 0.
- R4: Writing the increment and threshold without the update request leaves the output waveform unchanged.
- R5: On a disabled channel, a write with bit 30 set makes bit 30 read 1 in the cycle after the write edge and 0 one cycle later, with the new fields then active.
- R6: On an enabled channel, a write with bit 30 set keeps bit 30 at 1 until the accumulator wraps (carry out of the BU_W-bit sum). At the wrap the new fields become active and bit 30 clears.
- R7: While enabled, the accumulator adds the active increment every clock, starting from 0. The period is 2^BU_W / increment clocks when the increment divides 2^BU_W. While disabled, the accumulator is held at 0.
- R8: `pwm_out` is high exactly when enabled and the upper 8 accumulator bits are strictly greater than the active threshold. Over a period, the number of high cycles is the count of k in 0..P-1 with (k·inc)>>(BU_W-8) > thr.
- R9: Writing enable=0 forces `pwm_out` low from the next cycle on and keeps increment and threshold unchanged in the read-back.
- R10: If a write with bit 30 set lands in the same cycle as a pending transfer, the transfer still happens and the new request stays pending, so bit 30 reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:10] select the channel |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word, combinational |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The two functions that can fall in the same cycle are a pending shadow-to-active transfer and a fresh register write that carries a new update request. The bench provokes this on a disabled channel by issuing two back-to-back writes, both with bit 30 set. The second write lands exactly on the commit edge of the first. The bench judges the outcome in two ways: bit 30 must still read 1 after that edge, and the duty measured once the channel runs must match the second write's threshold. The same overlap on a running channel, where a write meets the wrap, is covered by a property that a requesting write always leaves the request pending.

// File: rtl/acc_pwm_pkg.sv
`timescale 1ns/1ps
package acc_pwm_pkg;
    localparam int REG_W    = 32;
    localparam int EN_POS   = 31;
    localparam int UPD_POS  = 30;
    localparam int BU_POS   = 8;
    localparam int DIV_W    = 8;
    localparam int WIN_BITS = 10;

    // state code is {enable, pending}
    typedef enum logic [1:0] {
        CS_STOP      = 2'b00,
        CS_STOP_LOAD = 2'b01,
        CS_RUN       = 2'b10,
        CS_RUN_ARMED = 2'b11
    } chan_state_e;
endpackage

// File: rtl/acc_pwm_decode.sv
`timescale 1ns/1ps
module acc_pwm_decode
    import acc_pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CSW    = 1,
    parameter int ADDR_W = 11
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [CSW-1:0]    sel_o,
    output logic [NUM_CH-1:0] ch_we_o
);
    logic [CSW-1:0]      idx;
    logic [WIN_BITS-1:0] off;

    assign idx   = addr_i[ADDR_W-1:WIN_BITS];
    assign off   = addr_i[WIN_BITS-1:0];
    assign hit_o = (off == '0) && (int'(idx) < NUM_CH);
    assign sel_o = idx;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        assign ch_we_o[c] = we_i && hit_o && (idx == CSW'(c));
    end
endmodule

// File: rtl/acc_pwm_ctrl.sv
`timescale 1ns/1ps
module acc_pwm_ctrl
    import acc_pwm_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             w_en_i,
    input  logic             w_upd_i,
    input  logic [BU_W-1:0]  w_base_i,
    input  logic [DIV_W-1:0] w_div_i,
    input  logic             wrap_i,
    output logic             en_o,
    output logic             upd_o,
    output logic [BU_W-1:0]  act_base_o,
    output logic [DIV_W-1:0] act_div_o,
    output logic [REG_W-1:0] cfg_o
);
    chan_state_e      state_q, state_d;
    logic             load;
    logic             en_next, pend_next;
    logic [BU_W-1:0]  shd_base_q;
    logic [DIV_W-1:0] shd_div_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_STOP;
        else        state_q <= state_d;
    end

    // transitions and commit strobe
    always_comb begin
        load = 1'b0;
        unique case (state_q)
            CS_STOP:      load = 1'b0;
            CS_STOP_LOAD: load = 1'b1;
            CS_RUN:       load = 1'b0;
            CS_RUN_ARMED: load = wrap_i;
        endcase
        en_next   = wr_i ? w_en_i : state_q[1];
        pend_next = (wr_i && w_upd_i) || (state_q[0] && !load);
        state_d   = chan_state_e'({en_next, pend_next});
    end

    // outputs decoded from state
    always_comb begin
        en_o  = 1'b0;
        upd_o = 1'b0;
        unique case (state_q)
            CS_STOP:      begin en_o = 1'b0; upd_o = 1'b0; end
            CS_STOP_LOAD: begin en_o = 1'b0; upd_o = 1'b1; end
            CS_RUN:       begin en_o = 1'b1; upd_o = 1'b0; end
            CS_RUN_ARMED: begin en_o = 1'b1; upd_o = 1'b1; end
        endcase
    end

    // shadow and active copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_base_q <= '0;
            shd_div_q  <= '0;
            act_base_o <= '0;
            act_div_o  <= '0;
        end else begin
            if (load) begin
                act_base_o <= shd_base_q;
                act_div_o  <= shd_div_q;
            end
            if (wr_i) begin
                shd_base_q <= w_base_i;
                shd_div_q  <= w_div_i;
            end
        end
    end

    always_comb begin
        cfg_o                    = '0;
        cfg_o[EN_POS]            = en_o;
        cfg_o[UPD_POS]           = upd_o;
        cfg_o[BU_POS +: BU_W]    = shd_base_q;
        cfg_o[DIV_W-1:0]         = shd_div_q;
    end
endmodule

// File: rtl/acc_pwm_gen.sv
`timescale 1ns/1ps
module acc_pwm_gen
    import acc_pwm_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [BU_W-1:0]  base_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             wrap_o,
    output logic             pwm_o
);
    localparam int TOP_LSB = BU_W - DIV_W;

    logic [BU_W-1:0] acc_q;
    logic [BU_W:0]   sum;

    assign sum    = {1'b0, acc_q} + {1'b0, base_i};
    assign wrap_o = en_i && sum[BU_W];

    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (en_i) acc_q <= sum[BU_W-1:0];
        else           acc_q <= '0;
    end

    assign pwm_o = en_i && (acc_q[BU_W-1:TOP_LSB] > div_i);
endmodule

// File: rtl/acc_pwm_bank.sv
`timescale 1ns/1ps
module acc_pwm_bank
    import acc_pwm_pkg::*;
#(
    parameter int  NUM_CH = 2,
    parameter int  BU_W   = 16,
    localparam int CSW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = WIN_BITS + CSW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic                         hit;
    logic [CSW-1:0]               sel;
    logic [NUM_CH-1:0]            ch_we, ch_en, ch_upd, ch_wrap;
    logic [NUM_CH-1:0][REG_W-1:0] ch_cfg;

    acc_pwm_decode #(.NUM_CH(NUM_CH), .CSW(CSW), .ADDR_W(ADDR_W)) u_dec (
        .we_i   (reg_we),
        .addr_i (reg_addr),
        .hit_o  (hit),
        .sel_o  (sel),
        .ch_we_o(ch_we)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [BU_W-1:0]  act_base;
        logic [DIV_W-1:0] act_div;

        acc_pwm_ctrl #(.BU_W(BU_W)) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (ch_we[c]),
            .w_en_i    (reg_wdata[EN_POS]),
            .w_upd_i   (reg_wdata[UPD_POS]),
            .w_base_i  (reg_wdata[BU_POS +: BU_W]),
            .w_div_i   (reg_wdata[DIV_W-1:0]),
            .wrap_i    (ch_wrap[c]),
            .en_o      (ch_en[c]),
            .upd_o     (ch_upd[c]),
            .act_base_o(act_base),
            .act_div_o (act_div),
            .cfg_o     (ch_cfg[c])
        );

        acc_pwm_gen #(.BU_W(BU_W)) u_gen (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (ch_en[c]),
            .base_i(act_base),
            .div_i (act_div),
            .wrap_o(ch_wrap[c]),
            .pwm_o (pwm_out[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (sel == CSW'(c)) reg_rdata = ch_cfg[c];
            end
        end
    end
endmodule

// File: rtl/acc_pwm_bank_chk.sv
`timescale 1ns/1ps
module acc_pwm_bank_chk #(
    parameter int NUM_CH = 2,
    parameter int BU_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [31:0]              reg_wdata,
    input logic [NUM_CH-1:0]        pwm_out,
    input logic [NUM_CH-1:0]        ch_we,
    input logic [NUM_CH-1:0]        ch_en,
    input logic [NUM_CH-1:0]        ch_upd,
    input logic [NUM_CH-1:0]        ch_wrap,
    input logic [NUM_CH-1:0][31:0]  ch_cfg
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        // R5
        a_r5_idle_commit: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_upd[i] && !ch_en[i] && !(ch_we[i] && reg_wdata[30])) |=> !ch_upd[i]);
        // R6
        a_r6_wait_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_upd[i] && ch_en[i] && !ch_wrap[i]) |=> ch_upd[i]);
        // R10
        a_r10_request_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_we[i] && reg_wdata[30]) |=> ch_upd[i]);
        // R9
        a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[i] && $past(!ch_en[i])) |-> !pwm_out[i]);
        // R2
        a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
            ch_we[i] |=> (ch_cfg[i][31] == $past(reg_wdata[31]))
                      && (ch_cfg[i][BU_W+7:0] == $past(reg_wdata[BU_W+7:0])));
    end
endmodule

bind acc_pwm_bank acc_pwm_bank_chk #(.NUM_CH(NUM_CH), .BU_W(BU_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wdata(reg_wdata),
    .pwm_out  (pwm_out),
    .ch_we    (ch_we),
    .ch_en    (ch_en),
    .ch_upd   (ch_upd),
    .ch_wrap  (ch_wrap),
    .ch_cfg   (ch_cfg)
);

// File: tb/tb_acc_pwm_bank.sv
`timescale 1ns/1ps
module tb_acc_pwm_bank;
    localparam int NUM_CH = 2;
    localparam int BU_W   = 16;
    localparam int ADDR_W = 11;
    localparam int NVEC   = 7;
    // {increment[15:0], threshold[7:0], period[7:0], expected high cycles[7:0]}
    localparam logic [39:0] VEC [NVEC] = '{
        {16'd4096,  8'd127, 8'd16, 8'd8},
        {16'd4096,  8'd0,   8'd16, 8'd15},
        {16'd4096,  8'd255, 8'd16, 8'd0},
        {16'd8192,  8'd63,  8'd8,  8'd6},
        {16'd2048,  8'd200, 8'd32, 8'd6},
        {16'd16384, 8'd100, 8'd4,  8'd2},
        {16'd1024,  8'd10,  8'd64, 8'd61}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    acc_pwm_bank #(.NUM_CH(NUM_CH), .BU_W(BU_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input bit en, input bit upd, input logic [15:0] b, input logic [7:0] d);
        return {en, upd, 6'd0, b, d};
    endfunction

    // write at one edge; returns at the following negedge with we low
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic count_high(input int ch, input int cycles, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            if (pwm_out[ch]) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(11'h000, r); check(r == 0, "R1 ch0 word", r, 0);
        rd(11'h400, r); check(r == 0, "R1 ch1 word", r, 0);
        check(pwm_out == 0, "R1 outputs", pwm_out, 0);

        // table walk: R5 idle commit, R7 period, R8 duty, R9 disable
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] b;
            logic [7:0]  d, p, e;
            {b, d, p, e} = VEC[v];
            wr(11'h000, word(1'b0, 1'b1, b, d));
            rd(11'h000, r); check(r[30] == 1'b1, "R5 request visible", r[30], 1);
            @(negedge clk);
            rd(11'h000, r); check(r[30] == 1'b0, "R5 request cleared", r[30], 0);
            wr(11'h000, word(1'b1, 1'b0, b, d));
            count_high(0, int'(p), n);
            check(n == int'(e), "R8 high cycles per period", n, e);
            wr(11'h000, word(1'b0, 1'b0, b, d));
            rd(11'h000, r); check(r == word(1'b0, 1'b0, b, d), "R9 fields kept", r, word(1'b0, 1'b0, b, d));
            count_high(0, int'(p), n);
            check(n == 0, "R9 output low when off", n, 0);
        end

        // R7: rising edges every 16 clocks with increment 4096, threshold 127
        wr(11'h000, word(1'b0, 1'b1, 16'd4096, 8'd127));
        @(negedge clk);
        wr(11'h000, word(1'b1, 1'b0, 16'd4096, 8'd127));
        begin
            int rises = 0;
            int first = -1;
            logic prev = 1'b0;
            for (int k = 0; k < 64; k++) begin
                if (pwm_out[0] && !prev) begin
                    rises++;
                    if (first < 0) first = k;
                end
                prev = pwm_out[0];
                @(negedge clk);
            end
            check(rises == 4, "R7 rises in 64 clocks", rises, 4);
            check(first == 8, "R7 first rise from zero", first, 8);
        end

        // R4: shadow write without request leaves waveform alone
        wr(11'h000, word(1'b1, 1'b0, 16'd4096, 8'd0));
        count_high(0, 16, n);
        check(n == 8, "R4 duty unchanged", n, 8);
        rd(11'h000, r); check(r[7:0] == 8'd0, "R2 shadow threshold read", r[7:0], 0);

        // R6: request while running waits for the wrap
        wr(11'h000, word(1'b1, 1'b1, 16'd4096, 8'd0));
        rd(11'h000, r); check(r[30] == 1'b1, "R6 request pending", r[30], 1);
        n = 0;
        while (r[30] && n < 40) begin
            @(negedge clk);
            n++;
            rd(11'h000, r);
        end
        check(n >= 1 && n <= 16, "R6 commit within one period", n, 16);
        count_high(0, 16, n);
        check(n == 15, "R6 new duty active", n, 15);

        // R9: disable mid-run
        wr(11'h000, word(1'b0, 1'b0, 16'd4096, 8'd0));
        check(pwm_out[0] == 1'b0, "R9 low after disable", pwm_out[0], 0);
        rd(11'h000, r); check(r == word(1'b0, 1'b0, 16'd4096, 8'd0), "R9 word after disable", r, word(1'b0, 1'b0, 16'd4096, 8'd0));

        // R10: second request lands on the commit edge of the first
        @(negedge clk);
        reg_addr = 11'h000; reg_we = 1'b1;
        reg_wdata = word(1'b0, 1'b1, 16'd4096, 8'd255);
        @(negedge clk);
        reg_wdata = word(1'b0, 1'b1, 16'd4096, 8'd0);
        @(negedge clk);
        reg_we = 1'b0;
        rd(11'h000, r); check(r[30] == 1'b1, "R10 request still pending", r[30], 1);
        @(negedge clk);
        rd(11'h000, r); check(r[30] == 1'b0, "R10 request committed", r[30], 0);
        wr(11'h000, word(1'b1, 1'b0, 16'd4096, 8'd0));
        count_high(0, 16, n);
        check(n == 15, "R10 second threshold active", n, 15);
        wr(11'h000, word(1'b0, 1'b0, 16'd4096, 8'd0));

        // R3: channel stride and undecoded offsets
        wr(11'h400, 32'h0012_3456);
        rd(11'h400, r); check(r == 32'h0012_3456, "R3 ch1 readback", r, 32'h0012_3456);
        rd(11'h000, r); check(r == word(1'b0, 1'b0, 16'd4096, 8'd0), "R3 ch0 untouched", r, word(1'b0, 1'b0, 16'd4096, 8'd0));
        wr(11'h004, 32'hBFFF_FFFF);
        rd(11'h004, r); check(r == 0, "R3 offset read zero", r, 0);
        rd(11'h000, r); check(r == word(1'b0, 1'b0, 16'd4096, 8'd0), "R3 offset write ignored", r, word(1'b0, 1'b0, 16'd4096, 8'd0));
        check(pwm_out == 0, "R3 outputs stay low", pwm_out, 0);

        // R2: pad bits read zero
        wr(11'h400, 32'h3FFF_FFAB);
        rd(11'h400, r); check(r == 32'h00FF_FFAB, "R2 pad bits zero", r, 32'h00FF_FFAB);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule